// File: doc/BRIEF.md
# Sixteen-Channel Event Counter Bank with Snapshot Readout

The block holds sixteen 32-bit event counters. Each counter advances on rising edges of its own pulse input. A single global inhibit input freezes all of them at once. A bus master reads the counters through a plain read port. The port takes a byte address, a one-cycle read strobe and a size flag. The flag selects either one 32-bit access or a 16-bit access to one half of a counter. In the 16-bit case the more significant half sits at the lower address.

A read of the upper half latches the whole counter value into a per-channel snapshot register. A later read of the lower half then returns the other half of that same value. The low half stays correct even if the counter has kept moving in between. A full-width read or an upper-half read also records whether counting was enabled at that moment. This record is kept in bit 7 of an 8-bit status output. A value of 1 there warns the reader that the value was taken while the counter could change.

Read data comes back one clock after the strobe, together with a valid pulse. A read of any address that is not a counter returns zero and changes no state.

Top module: `cnt_snap_bank`

## Requirements
- R1: Each of the 16 counters increments by exactly one for every rising edge on its own bit of `pulse_i` while `inhibit_i` is low. Other channels are unaffected.
- R2: While `inhibit_i` is high, no counter changes, whatever `pulse_i` does.
- R3: A read with `word_i`=0 at byte address 0x10+4*n returns the full 32-bit count of channel n on `rdata_o`, in the cycle after the strobe.
- R4: A read with `word_i`=1 at 0x10+4*n returns count bits 31..16 on `rdata_o[15:0]`, with `rdata_o[31:16]` zero. The same read stores the full 32-bit count as the snapshot of channel n.
- R5: A read with `word_i`=1 at 0x12+4*n returns bits 15..0 of channel n's snapshot on `rdata_o[15:0]`, with the upper half zero. It returns the snapshot even when the live counter has changed since the snapshot was taken.
- R6: A full-width read or an upper-half read sets `stat_o[7]` to 1 if `inhibit_i` was low at the strobe, and to 0 if it was high. A lower-half read leaves `stat_o` unchanged. Bits 6..0 of `stat_o` are always zero.
- R7: A full-width read also stores its value as the channel's snapshot. A lower-half read that is not preceded by an upper-half read returns the low half of the most recent snapshot, or zero if the channel has never been read.
- R8: A read at an address outside 0x10..0x4F returns zero. So does a read at an odd address, and so does a full-width read at an address with bit 1 set. Such a read leaves `stat_o` and every snapshot unchanged.
- R9: While `rst_ni` is low, all counters, snapshots, `stat_o`, `rdata_o` and `rvalid_o` are cleared.
- R10: `rvalid_o` is high in exactly the cycles that follow a cycle with `rd_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 16 | Event pulse per channel, asynchronous to the clock |
| inhibit_i | input | 1 | Global count inhibit, active high |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 8 | Byte address of the access |
| word_i | input | 1 | 1 selects a 16-bit half access, 0 a 32-bit access |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid |
| stat_o | output | 8 | Status; bit 7 set when the last capturing read saw counting enabled |

## Verification
The bench drives one counter above 65535, so the two halves hold distinct values. It then advances that counter between the upper-half read and the lower-half read. A design that read the live counter on the lower half would return the advanced value instead of the snapshot. The bench toggles the inhibit between the two halves of a split read. A design that also captured the flag on the lower half would flip `stat_o[7]`. It issues misaligned, odd and out-of-range reads before re-reading a lower half. A design that let a stray decode slip through would return nonzero data or disturb the snapshot or the flag. It also reads lower halves of channels whose snapshot came only from a full-width read, or from no read at all.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;
  localparam int unsigned NCH_DEF  = 16;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned HALF_W   = CNT_W / 2;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned SYNC_N   = 2;
  localparam logic [ADDR_W-1:0] CNT_BASE = 8'h10;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LONG = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LO   = 2'd3
  } acc_e;
endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cnt_chan.sv
module cnt_chan #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             inhibit_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic rise;
  logic [WIDTH-1:0] cnt_q;

  pulse_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pulse_i),
    .rise_o (rise)
  );

  // wraps to zero past all-ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (rise && !inhibit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_inhibit_freezes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> $stable(cnt_o));

  assert_step_of_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/rd_decode.sv
module rd_decode
  import cnt_snap_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   word_i,
  output acc_e                   kind_o,
  output logic [$clog2(NCH)-1:0] ch_o
);
  localparam int unsigned CH_W = $clog2(NCH);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NCH * 4);

  logic [ADDR_W-1:0] off;
  logic              in_win;

  assign off    = addr_i - CNT_BASE;
  assign in_win = (addr_i >= CNT_BASE) && ({1'b0, off} < SPAN) && !addr_i[0];
  assign ch_o   = off[CH_W+1:2];

  always_comb begin
    kind_o = ACC_NONE;
    if (in_win) begin
      if (word_i)          kind_o = addr_i[1] ? ACC_LO : ACC_HI;
      else if (!addr_i[1]) kind_o = ACC_LONG;
    end
  end
endmodule

// File: rtl/cnt_snap_bank.sv
module cnt_snap_bank
  import cnt_snap_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pulse_i,
  input  logic              inhibit_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned CH_W = $clog2(NCH);

  logic [CNT_W-1:0] cnt  [NCH];
  logic [CNT_W-1:0] snap [NCH];
  logic [CH_W-1:0]  ch;
  acc_e             kind;
  logic             live_q;
  logic [CNT_W-1:0] rdata_q;
  logic             rvalid_q;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    cnt_chan #(.WIDTH(CNT_W), .STAGES(SYNC_N)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pulse_i   (pulse_i[g]),
      .inhibit_i (inhibit_i),
      .cnt_o     (cnt[g])
    );
  end

  rd_decode #(.NCH(NCH)) u_dec (
    .addr_i (addr_i),
    .word_i (word_i),
    .kind_o (kind),
    .ch_o   (ch)
  );

  // upper-half and full reads latch the snapshot and the live flag; lower half only replays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      live_q   <= 1'b0;
      for (int i = 0; i < NCH; i++) snap[i] <= '0;
    end else begin
      rvalid_q <= rd_i;
      rdata_q  <= '0;
      if (rd_i) begin
        unique case (kind)
          ACC_LONG: begin
            rdata_q  <= cnt[ch];
            snap[ch] <= cnt[ch];
            live_q   <= ~inhibit_i;
          end
          ACC_HI: begin
            rdata_q  <= {{HALF_W{1'b0}}, cnt[ch][CNT_W-1:HALF_W]};
            snap[ch] <= cnt[ch];
            live_q   <= ~inhibit_i;
          end
          ACC_LO:   rdata_q <= {{HALF_W{1'b0}}, snap[ch][HALF_W-1:0]};
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  always_comb begin
    stat_o           = '0;
    stat_o[FLAG_BIT] = live_q;
  end

  assert_valid_after_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  assert_no_valid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  assert_half_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && word_i) |=> (rdata_o[CNT_W-1:HALF_W] == '0));
  assert_flag_from_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (kind == ACC_LONG || kind == ACC_HI)) |=> (stat_o[FLAG_BIT] == !$past(inhibit_i)));
  assert_lo_keeps_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && kind == ACC_LO) |=> $stable(stat_o));
  assert_bad_addr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && kind == ACC_NONE) |=> (rdata_o == '0 && $stable(stat_o)));
endmodule

// File: tb/sim_cnt_snap_bank.sv
module sim_cnt_snap_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  typedef struct {
    logic [31:0] data;
    logic        flag;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pulse_i = '0;
  logic        inhibit_i = 1'b1;
  logic        rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        word_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [7:0]  stat_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t exp_q[$];

  logic [31:0] m_cnt  [NCH];
  logic [31:0] m_snap [NCH];
  logic        m_flag;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cnt_snap_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i), .inhibit_i(inhibit_i),
    .rd_i(rd_i), .addr_i(addr_i), .word_i(word_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .stat_o(stat_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rvalid", 32'h1, 32'h0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(rdata_o === it.data, it.req, rdata_o, it.data);
        chk(stat_o === {it.flag, 7'h0}, {it.req, " R6 stat"}, {24'h0, stat_o}, {24'h0, it.flag, 7'h0});
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      pulse_i[ch] = 1'b1;
      if (!inhibit_i) m_cnt[ch] = m_cnt[ch] + 1;
      @(negedge clk_i);
      pulse_i[ch] = 1'b0;
    end
    settle(4);
  endtask

  // driver: expected value from the address map in the requirements
  task automatic rd(input logic [7:0] a, input logic w, input string req);
    item_t it;
    int ch;
    bit win;
    win = (a >= 8'h10) && (a <= 8'h4F) && !a[0];
    ch  = (int'(a) - 16) >> 2;
    it.data = '0;
    if (win && w && !a[1]) begin
      it.data = {16'h0, m_cnt[ch][31:16]};
      m_snap[ch] = m_cnt[ch];
      m_flag = !inhibit_i;
    end else if (win && w && a[1]) begin
      it.data = {16'h0, m_snap[ch][15:0]};
    end else if (win && !w && !a[1]) begin
      it.data = m_cnt[ch];
      m_snap[ch] = m_cnt[ch];
      m_flag = !inhibit_i;
    end
    it.flag = m_flag;
    it.req  = req;
    @(negedge clk_i);
    exp_q.push_back(it);
    rd_i = 1'b1; addr_i = a; word_i = w;
    @(negedge clk_i);
    rd_i = 1'b0;
    settle(1);
    chk(rvalid_o === 1'b0, "R10 rvalid drops", {31'h0, rvalid_o}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin m_cnt[i] = '0; m_snap[i] = '0; end
    m_flag = 1'b0;
    settle(3);
    chk(rvalid_o === 1'b0 && rdata_o === '0 && stat_o === '0, "R9 reset outputs",
        {rdata_o[30:0], rvalid_o}, 32'h0);
    rst_ni = 1'b1;
    settle(2);
    rd(8'h10, 1'b0, "R9 ch0 zero after reset");
    rd(8'h4C, 1'b0, "R9 ch15 zero after reset");
    rd(8'h12, 1'b1, "R9 snapshot zero after reset");

    inhibit_i = 1'b0;
    pulse(0, 3); pulse(5, 7); pulse(15, 1);
    rd(8'h10, 1'b0, "R1 R3 ch0 count");
    rd(8'h24, 1'b0, "R1 R3 ch5 count");
    rd(8'h4C, 1'b0, "R1 R3 ch15 count");

    inhibit_i = 1'b1;
    pulse(5, 4);
    rd(8'h24, 1'b0, "R2 ch5 frozen, R6 flag 0");

    inhibit_i = 1'b0;
    pulse(7, 65540);
    rd(8'h2C, 1'b1, "R4 ch7 upper half");
    pulse(7, 3);
    inhibit_i = 1'b1;
    rd(8'h2E, 1'b1, "R5 ch7 lower half from snapshot, R6 flag kept");
    rd(8'h2C, 1'b0, "R3 ch7 full after more pulses");

    rd(8'h26, 1'b1, "R7 ch5 lower from long snapshot");
    rd(8'h36, 1'b1, "R7 ch9 never read");

    inhibit_i = 1'b0;
    rd(8'h50, 1'b0, "R8 above window");
    rd(8'h0C, 1'b0, "R8 below window");
    rd(8'h11, 1'b1, "R8 odd address");
    rd(8'h2E, 1'b0, "R8 long at half offset");
    rd(8'h2E, 1'b1, "R8 snapshot kept");

    settle(3);
    chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule